// File: doc/BRIEF.md
# Cut-Through Cell-to-Frame Forwarder

This block accepts a packet that arrives as a train of fixed-size cell payloads on a slow byte stream. It sends the packet out again as a framed packet on a faster byte stream. Payload bytes enter an internal FIFO. Bytes that lie past the packet length, which is the padding at the end of the final cell, are dropped before they reach the FIFO. A counter tracks how many packet bytes have been kept so far.

Transmission is held back until two conditions hold. First, enough bytes must be buffered that the faster output can send the rest of the packet without running dry. Second, a minimum latency must have passed since the first byte arrived. The block then sends an 8-byte preamble and the packet bytes, one byte per output slot, with no gaps between them. It raises sticky flags if the FIFO runs empty mid-packet or if a write arrives while the FIFO is full.

The start threshold is a parameter. It is sized from the ratio of the input and output rates and from the packet length, so that the write side always stays ahead of the read side.

Top module: `cell_to_frame_fwd`

## Requirements
- R1: During reset and right after it, `out_valid`, `out_last`, `underrun_err` and `overflow_err` are 0.
- R2: A packet of length L arrives as ceil(L/CELL_BYTES)*CELL_BYTES bytes starting with the `in_sop` byte. Only payload indices 0..L-1 are forwarded, and the padding bytes that follow them never appear at the output.
- R3: Every packet starts with 8 preamble bytes, seven 0x55 followed by one 0xD5, before any packet byte.
- R4: After the preamble, the L packet bytes appear in arrival order with their values unchanged. `out_last` is 1 on the final packet byte only.
- R5: The first preamble byte comes out only after the kept-byte count has reached min(START_BYTES, L) and at least MIN_LAT cycles have passed since the first byte was taken. It is sent in the first output slot once both conditions are registered.
- R6: Output is slot-paced. `out_valid` rises only in the cycle after an `out_en` pulse, and carries at most one byte per pulse.
- R7: While the FIFO is not empty, every `out_en` pulse from the first preamble byte to the last packet byte yields a byte, so there is no gap.
- R8: If an output slot comes during the packet bytes while the FIFO is empty, `underrun_err` goes to 1 and stays at 1 until reset.
- R9: A payload byte written while the FIFO already holds FIFO_DEPTH bytes is dropped, and `overflow_err` goes to 1 and stays at 1 until reset.
- R10: After the last packet byte the block is idle. It handles the next packet without a reset, and emits nothing while idle.
- R11: Input bytes with `in_valid` high that arrive when no packet is open and `in_sop` is low are ignored. They produce no output and do not enter the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input payload byte is present |
| in_sop | input | 1 | The byte is payload index 0 of a new packet |
| in_len | input | LEN_W | Packet length in bytes, sampled with `in_sop` |
| in_byte | input | 8 | Input payload byte |
| out_en | input | 1 | Output slot pulse, one byte per pulse |
| out_valid | output | 1 | An output byte is present |
| out_byte | output | 8 | Output byte (preamble or packet byte) |
| out_last | output | 1 | Final packet byte |
| underrun_err | output | 1 | Sticky: the FIFO was empty in a data slot |
| overflow_err | output | 1 | Sticky: a write came while the FIFO was full |

## Verification
The main path is exercised with several rate patterns: input slower than output, input faster than output, and equal rates. Lengths cover a full multiple of the cell size, lengths that leave padding in the last cell, lengths shorter than the start threshold, and a single byte. A slow input with a fast output tells the threshold gate apart from the latency gate, since both bounds on the first preamble byte are checked. Short packets on a fast input show that the latency gate and the shortened threshold are in effect. Packets that end mid-cell show that padding is stripped. A deliberately starved output exposes the underrun flag, a stalled output exposes the overflow flag, and stray bytes with no open packet must leave the output silent.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_PRE  = 2'd1,
      TX_DATA = 2'd2
   } tx_state_t;

   localparam int PRE_BYTES = 8;
   localparam logic [7:0] PRE_FILL  = 8'h55;
   localparam logic [7:0] PRE_DELIM = 8'hD5;

   function automatic logic [7:0] preamble_byte(input int unsigned pos);
      return (pos == PRE_BYTES - 1) ? PRE_DELIM : PRE_FILL;
   endfunction

endpackage

// File: rtl/ctf_fifo.sv
module ctf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] level
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic [CW-1:0] cnt;
   logic          do_wr, do_rd;

   generate
      if (POW2) begin : g_wrap_free
         assign wnext = wptr + AW'(1);
         assign rnext = rptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign level   = cnt;
   assign do_wr   = wr_en && !full;
   assign do_rd   = rd_en && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wnext;
         if (do_rd) rptr <= rnext;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/ctf_rx.sv
module ctf_rx #(
   parameter int CELL_BYTES = 48,
   parameter int MAX_LEN    = 1518,
   parameter int MIN_LAT    = 10,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int SPAN_W    = $clog2(MAX_LEN + CELL_BYTES + 1),
   localparam int LAT_W     = $clog2(MIN_LAT + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [LEN_W-1:0] in_len,
   input  logic [7:0]       in_byte,
   input  logic             start_ack,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic [LEN_W-1:0] kept,
   output logic [LEN_W-1:0] pkt_len,
   output logic             lat_ok,
   output logic             pending
);

   logic              active_q, pend_q;
   logic [SPAN_W-1:0] idx_q, span_q;
   logic [LEN_W-1:0]  len_q, kept_q;
   logic [LAT_W-1:0]  lat_q;

   logic              accept, sop_acc, keep;
   logic [SPAN_W-1:0] idx_cur, span_new, len_ext;
   logic [LEN_W-1:0]  len_cur;

   always_comb begin
      sop_acc  = in_valid && in_sop;
      accept   = in_valid && (in_sop || active_q);
      len_cur  = in_sop ? in_len : len_q;
      idx_cur  = in_sop ? '0 : idx_q;
      len_ext  = SPAN_W'(in_len);
      span_new = SPAN_W'(((len_ext + SPAN_W'(CELL_BYTES - 1)) / SPAN_W'(CELL_BYTES))
                         * SPAN_W'(CELL_BYTES));
      keep     = accept && (idx_cur < SPAN_W'(len_cur));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pend_q   <= 1'b0;
         idx_q    <= '0;
         span_q   <= '0;
         len_q    <= '0;
         kept_q   <= '0;
         lat_q    <= '0;
      end else if (sop_acc) begin
         len_q    <= in_len;
         span_q   <= span_new;
         idx_q    <= SPAN_W'(1);
         active_q <= (span_new > SPAN_W'(1));
         kept_q   <= keep ? LEN_W'(1) : '0;
         lat_q    <= '0;
         pend_q   <= (in_len != '0);
      end else begin
         if (accept) begin
            idx_q <= idx_q + SPAN_W'(1);
            if (idx_q + SPAN_W'(1) >= span_q) active_q <= 1'b0;
            if (keep) kept_q <= kept_q + LEN_W'(1);
         end
         if (lat_q < LAT_W'(MIN_LAT)) lat_q <= lat_q + LAT_W'(1);
         if (start_ack) pend_q <= 1'b0;
      end
   end

   assign wr_en   = keep;
   assign wr_data = in_byte;
   assign kept    = kept_q;
   assign pkt_len = len_q;
   assign lat_ok  = (lat_q >= LAT_W'(MIN_LAT));
   assign pending = pend_q;

endmodule

// File: rtl/ctf_tx.sv
module ctf_tx
   import ctf_pkg::*;
#(
   parameter int MAX_LEN     = 1518,
   parameter int START_BYTES = 640,
   localparam int LEN_W      = $clog2(MAX_LEN + 1),
   localparam int PW         = $clog2(PRE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             out_en,
   input  logic             pending,
   input  logic             lat_ok,
   input  logic [LEN_W-1:0] kept,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_data,
   output logic             rd_en,
   output logic             start_ack,
   output tx_state_t        state,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             out_last,
   output logic             underrun_err
);

   tx_state_t        st_q;
   logic [PW-1:0]    pre_q;
   logic [LEN_W-1:0] sent_q, len_q, thr_eff;
   logic             data_slot, last_pre, last_data;

   always_comb begin
      thr_eff   = (pkt_len < LEN_W'(START_BYTES)) ? pkt_len : LEN_W'(START_BYTES);
      start_ack = (st_q == TX_IDLE) && pending && lat_ok && (kept >= thr_eff);
      data_slot = (st_q == TX_DATA) && out_en;
      rd_en     = data_slot && !fifo_empty;
      last_pre  = (pre_q == PW'(PRE_BYTES - 1));
      last_data = (sent_q == len_q - LEN_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= TX_IDLE;
         pre_q        <= '0;
         sent_q       <= '0;
         len_q        <= '0;
         out_valid    <= 1'b0;
         out_byte     <= '0;
         out_last     <= 1'b0;
         underrun_err <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         unique case (st_q)
            TX_IDLE: begin
               if (start_ack) begin
                  st_q   <= TX_PRE;
                  pre_q  <= '0;
                  sent_q <= '0;
                  len_q  <= pkt_len;
               end
            end
            TX_PRE: begin
               if (out_en) begin
                  out_valid <= 1'b1;
                  out_byte  <= preamble_byte(int'(pre_q));
                  pre_q     <= pre_q + PW'(1);
                  if (last_pre) st_q <= TX_DATA;
               end
            end
            TX_DATA: begin
               if (rd_en) begin
                  out_valid <= 1'b1;
                  out_byte  <= fifo_data;
                  out_last  <= last_data;
                  sent_q    <= sent_q + LEN_W'(1);
                  if (last_data) begin
                     st_q   <= TX_IDLE;
                     sent_q <= '0;
                  end
               end else if (data_slot) begin
                  underrun_err <= 1'b1;
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign state = st_q;

endmodule

// File: rtl/cell_to_frame_fwd.sv
module cell_to_frame_fwd
   import ctf_pkg::*;
#(
   parameter int CELL_BYTES  = 48,
   parameter int MAX_LEN     = 1518,
   parameter int FIFO_DEPTH  = 1024,
   parameter int START_BYTES = 640,
   parameter int MIN_LAT     = 10,
   localparam int LEN_W      = $clog2(MAX_LEN + 1),
   localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic [LEN_W-1:0] in_len,
   input  logic [7:0]       in_byte,
   input  logic             out_en,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             out_last,
   output logic             underrun_err,
   output logic             overflow_err
);

   generate
      if (CELL_BYTES < 1) begin : g_bad_cell
         $error("CELL_BYTES must be at least 1");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (START_BYTES < 1 || START_BYTES > MAX_LEN) begin : g_bad_thr
         $error("START_BYTES must lie in 1..MAX_LEN");
      end
      if (START_BYTES > FIFO_DEPTH) begin : g_bad_fit
         $error("FIFO_DEPTH must hold at least START_BYTES");
      end
      if (MIN_LAT < 0) begin : g_bad_lat
         $error("MIN_LAT must not be negative");
      end
   endgenerate

   logic             wr_en, rd_en, fifo_empty, fifo_full, start_ack;
   logic             lat_ok, pending;
   logic [7:0]       wr_data, fifo_data;
   logic [LEN_W-1:0] kept, pkt_len;
   logic [CW-1:0]    fifo_level;
   tx_state_t        tx_state;

   ctf_rx #(
      .CELL_BYTES (CELL_BYTES),
      .MAX_LEN    (MAX_LEN),
      .MIN_LAT    (MIN_LAT)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_len    (in_len),
      .in_byte   (in_byte),
      .start_ack (start_ack),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .kept      (kept),
      .pkt_len   (pkt_len),
      .lat_ok    (lat_ok),
      .pending   (pending)
   );

   ctf_fifo #(
      .W     (8),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (fifo_data),
      .empty   (fifo_empty),
      .full    (fifo_full),
      .level   (fifo_level)
   );

   ctf_tx #(
      .MAX_LEN     (MAX_LEN),
      .START_BYTES (START_BYTES)
   ) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .out_en       (out_en),
      .pending      (pending),
      .lat_ok       (lat_ok),
      .kept         (kept),
      .pkt_len      (pkt_len),
      .fifo_empty   (fifo_empty),
      .fifo_data    (fifo_data),
      .rd_en        (rd_en),
      .start_ack    (start_ack),
      .state        (tx_state),
      .out_valid    (out_valid),
      .out_byte     (out_byte),
      .out_last     (out_last),
      .underrun_err (underrun_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                      overflow_err <= 1'b0;
      else if (wr_en && fifo_full)     overflow_err <= 1'b1;
   end

endmodule

// File: rtl/ctf_checker.sv
module ctf_checker
   import ctf_pkg::*;
#(
   parameter int FIFO_DEPTH = 1024,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_en,
   input logic          out_valid,
   input logic [7:0]    out_byte,
   input logic          out_last,
   input logic          underrun_err,
   input logic          overflow_err,
   input tx_state_t     tx_state,
   input logic          fifo_empty,
   input logic [CW-1:0] fifo_level
);

   assert_valid_after_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(out_en));

   assert_last_is_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   assert_preamble_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state == TX_PRE && out_en) |=>
         (out_valid && (out_byte == PRE_FILL || out_byte == PRE_DELIM)));

   assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state == TX_DATA && out_en && !fifo_empty) |=> out_valid);

   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_err |=> underrun_err);

   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_err |=> overflow_err);

   assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= CW'(FIFO_DEPTH));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state == TX_IDLE && $past(tx_state) == TX_IDLE) |-> !out_valid);

endmodule

bind cell_to_frame_fwd ctf_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .out_en       (out_en),
   .out_valid    (out_valid),
   .out_byte     (out_byte),
   .out_last     (out_last),
   .underrun_err (underrun_err),
   .overflow_err (overflow_err),
   .tx_state     (tx_state),
   .fifo_empty   (fifo_empty),
   .fifo_level   (fifo_level)
);

// File: tb/cell_to_frame_fwd_test.sv
module cell_to_frame_fwd_test;

   localparam int CELL  = 8;
   localparam int MAXL  = 40;
   localparam int DEPTH = 32;
   localparam int THR   = 20;
   localparam int LAT   = 10;
   localparam int LEN_W = $clog2(MAXL + 1);

   // vector fields: length, input period, output period, data seed
   localparam logic [31:0] VECS [0:5] = '{
      {8'd40, 8'd3, 8'd2, 8'h11},
      {8'd17, 8'd2, 8'd1, 8'h42},
      {8'd5,  8'd1, 8'd1, 8'h90},
      {8'd24, 8'd1, 8'd3, 8'h07},
      {8'd33, 8'd4, 8'd2, 8'hC3},
      {8'd1,  8'd1, 8'd2, 8'h5A}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, out_en = 1'b0;
   logic [LEN_W-1:0] in_len = '0;
   logic [7:0] in_byte = '0;
   logic out_valid, out_last, underrun_err, overflow_err;
   logic [7:0] out_byte;

   always #5 clk = ~clk;

   cell_to_frame_fwd #(
      .CELL_BYTES(CELL), .MAX_LEN(MAXL), .FIFO_DEPTH(DEPTH),
      .START_BYTES(THR), .MIN_LAT(LAT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_len(in_len), .in_byte(in_byte), .out_en(out_en),
      .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
      .underrun_err(underrun_err), .overflow_err(overflow_err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // output monitor
   logic [7:0] got_b [0:63];
   bit         got_l [0:63];
   int  got_n = 0, first_cyc = -1, gaps = 0, slot_bad = 0;
   bit  in_frame = 0, prev_en = 0, seen_last = 0;

   always @(negedge clk) begin
      if (out_valid) begin
         if (got_n == 0) first_cyc = cyc;
         if (!prev_en) slot_bad++;
         if (got_n < 64) begin
            got_b[got_n] = out_byte;
            got_l[got_n] = out_last;
         end
         got_n++;
         in_frame = !out_last;
         if (out_last) seen_last = 1;
      end else if (in_frame && prev_en) begin
         gaps++;
      end
      prev_en = out_en;
   end

   task automatic mon_clear();
      got_n = 0; first_cyc = -1; gaps = 0; slot_bad = 0;
      in_frame = 0; seen_last = 0;
   endtask

   function automatic logic [7:0] byte_of(input int seed, input int idx, input int len);
      return (idx < len) ? 8'(seed + idx * 7) : 8'(8'hE0 + idx);
   endfunction

   task automatic send(input int len, input int in_per, input int out_per,
                       input int seed, input int tmo, output int t_ok);
      int span, idx, kept, s, thr_eff;
      span = ((len + CELL - 1) / CELL) * CELL;
      idx = 0; kept = 0; s = -1; t_ok = -1;
      thr_eff = (len < THR) ? len : THR;
      for (int k = 0; k < tmo; k++) begin
         @(posedge clk); #1;
         out_en = (out_per > 0) && (k % out_per == 0);
         if (idx < span && k % in_per == 0) begin
            in_valid = 1'b1;
            in_sop   = (idx == 0);
            in_len   = LEN_W'(len);
            in_byte  = byte_of(seed, idx, len);
            if (idx == 0) s = cyc;
            if (idx < len) kept++;
            idx++;
         end else begin
            in_valid = 1'b0;
            in_sop   = 1'b0;
         end
         if (t_ok < 0 && s >= 0 && kept >= thr_eff && cyc - s >= LAT) t_ok = cyc;
         if (seen_last && idx >= span) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sop = 1'b0; out_en = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic check_pkt(input int len, input int seed, input int out_per,
                            input int t_ok, input bit chained);
      int bad_pre, bad_dat, bad_last;
      bad_pre = 0; bad_dat = 0; bad_last = 0;
      chk(got_n == 8 + len, chained ? "R10 next packet count" : "R2 byte count", got_n, 8 + len);
      for (int i = 0; i < 8 && i < got_n; i++)
         if (got_b[i] != ((i == 7) ? 8'hD5 : 8'h55)) bad_pre++;
      chk(bad_pre == 0, "R3 preamble bytes", bad_pre, 0);
      for (int i = 0; i < len && 8 + i < got_n && 8 + i < 64; i++)
         if (got_b[8 + i] != byte_of(seed, i, len)) bad_dat++;
      chk(bad_dat == 0, "R4 data bytes", bad_dat, 0);
      for (int i = 0; i < got_n && i < 64; i++)
         if (got_l[i] != (i == 7 + len)) bad_last++;
      chk(bad_last == 0, "R4 last marker", bad_last, 0);
      chk(first_cyc >= t_ok + 3, "R5 start not early", first_cyc, t_ok + 3);
      chk(first_cyc <= t_ok + 2 + out_per, "R5 start not late", first_cyc, t_ok + 2 + out_per);
      chk(gaps == 0, "R7 no gaps", gaps, 0);
      chk(slot_bad == 0, "R6 slot pacing", slot_bad, 0);
      chk(underrun_err == 1'b0, "R8 no underrun", int'(underrun_err), 0);
      chk(overflow_err == 1'b0, "R9 no overflow", int'(overflow_err), 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs idle in reset",
          int'(out_valid), 0);
      chk(underrun_err == 1'b0 && overflow_err == 1'b0, "R1 flags clear in reset",
          int'(underrun_err) + int'(overflow_err), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      mon_clear();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int t_ok;
      do_reset();
      chk(out_valid == 1'b0, "R1 idle after reset", int'(out_valid), 0);

      // table of rate / length patterns, chained without reset (R10)
      foreach (VECS[i]) begin
         mon_clear();
         send(int'(VECS[i][31:24]), int'(VECS[i][23:16]), int'(VECS[i][15:8]),
              int'(VECS[i][7:0]), 2000, t_ok);
         check_pkt(int'(VECS[i][31:24]), int'(VECS[i][7:0]), int'(VECS[i][15:8]),
                   t_ok, i > 0);
      end

      // R11: stray bytes with no open packet
      mon_clear();
      for (int k = 0; k < 12; k++) begin
         @(posedge clk); #1;
         in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'(8'hA0 + k); out_en = 1'b1;
      end
      @(posedge clk); #1;
      in_valid = 1'b0; out_en = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(got_n == 0, "R11 stray bytes silent", got_n, 0);
      mon_clear();
      send(12, 2, 1, 8'h33, 2000, t_ok);
      check_pkt(12, 8'h33, 1, t_ok, 1'b1);

      // R8: starved output
      mon_clear();
      send(40, 8, 1, 8'h21, 2000, t_ok);
      chk(underrun_err == 1'b1, "R8 underrun flagged", int'(underrun_err), 1);
      repeat (5) @(posedge clk);
      #1;
      chk(underrun_err == 1'b1, "R8 underrun sticky", int'(underrun_err), 1);

      do_reset();

      // R9: stalled output
      send(40, 1, 0, 8'h66, 60, t_ok);
      chk(overflow_err == 1'b1, "R9 overflow flagged", int'(overflow_err), 1);
      chk(got_n == 0, "R6 no output without slots", got_n, 0);
      repeat (4) @(posedge clk);
      #1;
      chk(overflow_err == 1'b1, "R9 overflow sticky", int'(overflow_err), 1);

      do_reset();
      chk(overflow_err == 1'b0, "R1 reset clears overflow", int'(overflow_err), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule